// File: doc/BRIEF.md
# Seven-to-one parallel-to-serial link transmitter

The block takes a 28-bit parallel word once per pixel clock and spreads it across four serial data lanes, seven bits per lane per pixel cycle, using a bit clock that runs at seven times the pixel rate and is locked to it. A fifth serial lane sends a fixed seven-bit clock pattern framed exactly like the data, so a receiver can recover both the pixel rate and the word boundary. A static select input decides whether the word is taken on the rising or on the falling pixel-clock edge.

Two protective functions sit around the serializer. A detector clocked by a free-running reference clock notices when the pixel clock has stopped and forces every lane low. Once the clock comes back, the lanes stay low until two properly aligned frames have gone by. An active-low power-down input, filtered so that only levels held for a minimum time count, turns off the output enables of all five lanes. Differential drivers, the clock multiplier and all analog behaviour lie outside the block.

Top module: `ser7_tx`

## Requirements
- R1: Input bits 7k to 7k+6 leave on data lane k (ser_o[k], k = 0..3), highest-indexed bit first. Bit 7k+6 goes out in the bit slot where the clock lane starts its pattern.
- R2: One captured word is sent in every pixel cycle, and words sampled in consecutive pixel cycles come out in consecutive seven-bit frames with no gap and no repeat.
- R3: The clock lane (ser_o[4]) sends 1,1,0,0,0,1,1 in every frame, with its first bit in the same slot as the first data bit. The lane therefore never holds more than four ones or three zeros in a row.
- R4: With edge_rise = 1 the word present at the rising pixel-clock edge is sent. With edge_rise = 0 the word present at the falling edge is sent.
- R5: If no pixel-clock edge arrives for MISS_LIMIT (default 64) reference-clock cycles, all five serial bits are driven low while the enables stay on. A stop shorter than that leaves the clock pattern running.
- R6: After the pixel clock returns, the lanes stay low for at least the first 1.5 pixel periods. They resume with the clock pattern once two frames have started exactly on a pixel-clock edge.
- R7: A change of pd_n takes effect only after the new level has been held for PD_HOLD (default 200) reference-clock cycles. A shorter pulse has no effect on the enables.
- R8: While power-down is in force, all five ser_oe bits are 0 and all ser_o bits are 0. Otherwise all five ser_oe bits are 1.
- R9: During reset, ser_oe and ser_o are all 0. After reset the enables turn on only once pd_n has been high for PD_HOLD reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock, one word per period |
| bit_clk | input | 1 | Serial bit clock, seven times pix_clk and locked to it |
| ref_clk | input | 1 | Free-running reference clock for the clock detector and the power-down filter |
| rst_n | input | 1 | Synchronous active-low reset, applied in all three clock domains |
| edge_rise | input | 1 | Static capture-edge select: 1 rising, 0 falling |
| pd_n | input | 1 | Active-low power-down request |
| data_i | input | 28 | Parallel word |
| ser_o | output | 5 | Serial bits: [3:0] data lanes, [4] clock lane |
| ser_oe | output | 5 | Output enable for each serial bit |

## Verification
A captured word reaches the lanes after a fixed number of frames (a two-stage synchronizer, then the holding register, then the shift registers). The bench therefore does not count bit cycles from the stimulus. It decodes the serial stream on the falling bit-clock edge, finds the frame boundary from the three-zero run of the clock lane, locks onto the first table word and then requires each later frame to carry the next word. For the clock detector and the power-down filter, the bench waits out the synchronizer and threshold delays (64 or 200 reference cycles plus at most a few cycles) with margin on both sides, and samples the ports on the opposite edge of the clock that drives them.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
// Shared constants of the seven-to-one serializer.
// Assumes the serialization ratio and the clock-lane pattern are fixed per build.
package ser7_pkg;
    localparam int          SER_LANES   = 4;
    localparam int          SER_RATIO   = 7;
    localparam int          SER_WORD_W  = SER_LANES * SER_RATIO;
    localparam logic [6:0]  SER_CLK_PAT = 7'b1100011;
    localparam int          SER_GOOD_FR = 2;
endpackage

// File: rtl/ser7_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for W independent single-bit level signals.
// Assumes each bit is a slow level or a clock sampled well below Nyquist.
module ser7_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // two register stages into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
// Samples the parallel word on both pixel-clock edges and selects one by edge_rise.
// Assumes edge_rise is static during operation.
module ser7_capture #(
    parameter int W = 28
) (
    input  logic         pix_clk,
    input  logic         rst_n,
    input  logic         edge_rise,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_o
);
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    // rising-edge sample
    always_ff @(posedge pix_clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= din;
    end

    // falling-edge sample
    always_ff @(negedge pix_clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din;
    end

    assign word_o = edge_rise ? rise_q : fall_q;
endmodule

// File: rtl/ser7_ref_monitor.sv
`timescale 1ns/1ps
// Reference-clock side: flags a stopped pixel clock and filters the power-down pin.
// Assumes ref_clk samples each pixel-clock phase at least once.
module ser7_ref_monitor #(
    parameter int MISS_LIMIT = 64,
    parameter int PD_HOLD    = 200
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic pd_n,
    output logic clk_lost,
    output logic pwr_on
);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam int PW = $clog2(PD_HOLD + 1);

    logic [1:0]    sampled;
    logic          pix_r;
    logic          pd_r;
    logic          pix_d;
    logic          pix_edge;
    logic [MW-1:0] miss_cnt;
    logic [PW-1:0] pd_cnt;

    ser7_sync #(.W(2)) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     ({pd_n, pix_clk}),
        .q     (sampled)
    );
    assign pix_r = sampled[0];
    assign pd_r  = sampled[1];

    // delayed copy for edge detection
    always_ff @(posedge ref_clk) begin
        if (!rst_n) pix_d <= 1'b0;
        else        pix_d <= pix_r;
    end
    assign pix_edge = pix_r ^ pix_d;

    // cycles since the last pixel-clock edge, saturating at the limit
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                           miss_cnt <= '0;
        else if (pix_edge)                    miss_cnt <= '0;
        else if (miss_cnt != MW'(MISS_LIMIT)) miss_cnt <= miss_cnt + 1'b1;
    end
    assign clk_lost = (miss_cnt == MW'(MISS_LIMIT));

    // accept a new pd level only after it has held PD_HOLD cycles
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pwr_on <= 1'b0;
            pd_cnt <= '0;
        end else if (pd_r == pwr_on) begin
            pd_cnt <= '0;
        end else if (pd_cnt == PW'(PD_HOLD - 1)) begin
            pwr_on <= pd_r;
            pd_cnt <= '0;
        end else begin
            pd_cnt <= pd_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ser7_lanes.sv
`timescale 1ns/1ps
// Bit-clock side: frame counter aligned to the pixel clock, holding register,
// one shift register per lane plus the clock lane, and the output gating.
// Assumes bit_clk is RATIO times pix_clk and phase-locked to it.
module ser7_lanes #(
    parameter int             LANES   = 4,
    parameter int             RATIO   = 7,
    parameter logic [RATIO-1:0] CLK_PAT = 7'b1100011,
    parameter int             GOOD_FR = 2
) (
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   pix_s,
    input  logic                   lost_s,
    input  logic                   pwr_s,
    input  logic [LANES*RATIO-1:0] word_i,
    output logic [LANES:0]         ser_o,
    output logic [LANES:0]         ser_oe,
    output logic                   force_low
);
    localparam int SW = $clog2(RATIO);
    localparam int GW = $clog2(GOOD_FR + 1);
    localparam logic [SW-1:0] LAST = SW'(RATIO - 1);

    logic                   pix_d;
    logic                   frame_rise;
    logic                   frame_end;
    logic [SW-1:0]          slot;
    logic [GW-1:0]          good;
    logic [LANES*RATIO-1:0] hold;
    logic [RATIO-1:0]       clk_sh;
    logic [LANES-1:0]       lane_bit;

    // delayed pixel level for rising-edge detect
    always_ff @(posedge bit_clk) begin
        if (!rst_n) pix_d <= 1'b0;
        else        pix_d <= pix_s;
    end
    assign frame_rise = pix_s & ~pix_d;
    assign frame_end  = (slot == LAST);

    // bit slot within the frame, realigned on every pixel edge
    always_ff @(posedge bit_clk) begin
        if (!rst_n)                      slot <= '0;
        else if (frame_rise | frame_end) slot <= '0;
        else                             slot <= slot + 1'b1;
    end

    // holding register takes the settled captured word
    always_ff @(posedge bit_clk) begin
        if (!rst_n)          hold <= '0;
        else if (frame_rise) hold <= word_i;
    end

    // per-lane shift registers, MSB first
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [RATIO-1:0] sh;
        // load at the frame boundary, else shift toward the MSB
        always_ff @(posedge bit_clk) begin
            if (!rst_n)         sh <= '0;
            else if (frame_end) sh <= hold[k*RATIO +: RATIO];
            else                sh <= {sh[RATIO-2:0], 1'b0};
        end
        assign lane_bit[k] = sh[RATIO-1];
    end

    // clock-lane pattern shifter
    always_ff @(posedge bit_clk) begin
        if (!rst_n)         clk_sh <= '0;
        else if (frame_end) clk_sh <= CLK_PAT;
        else                clk_sh <= {clk_sh[RATIO-2:0], 1'b0};
    end

    // count frames that start exactly on a pixel edge
    always_ff @(posedge bit_clk) begin
        if (!rst_n)          good <= '0;
        else if (lost_s)     good <= '0;
        else if (frame_rise) begin
            if (!frame_end)                  good <= '0;
            else if (good != GW'(GOOD_FR))   good <= good + 1'b1;
        end
    end
    assign force_low = (good != GW'(GOOD_FR));

    assign ser_o  = (force_low | ~pwr_s) ? '0 : {clk_sh[RATIO-1], lane_bit};
    assign ser_oe = {(LANES+1){pwr_s}};
endmodule

// File: rtl/ser7_tx.sv
`timescale 1ns/1ps
// Top of the seven-to-one serializer: capture, reference-clock monitor,
// synchronizers into the bit domain and the lane serializers.
// Assumes bit_clk is locked to pix_clk and ref_clk runs freely.
module ser7_tx
    import ser7_pkg::*;
#(
    parameter int MISS_LIMIT = 64,
    parameter int PD_HOLD    = 200
) (
    input  logic                  pix_clk,
    input  logic                  bit_clk,
    input  logic                  ref_clk,
    input  logic                  rst_n,
    input  logic                  edge_rise,
    input  logic                  pd_n,
    input  logic [SER_WORD_W-1:0] data_i,
    output logic [SER_LANES:0]    ser_o,
    output logic [SER_LANES:0]    ser_oe
);
    logic [SER_WORD_W-1:0] cap_word;
    logic                  clk_lost;
    logic                  pwr_on;
    logic [2:0]            to_bit;
    logic                  force_b;

    ser7_capture #(.W(SER_WORD_W)) u_cap (
        .pix_clk   (pix_clk),
        .rst_n     (rst_n),
        .edge_rise (edge_rise),
        .din       (data_i),
        .word_o    (cap_word)
    );

    ser7_ref_monitor #(.MISS_LIMIT(MISS_LIMIT), .PD_HOLD(PD_HOLD)) u_mon (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .pix_clk  (pix_clk),
        .pd_n     (pd_n),
        .clk_lost (clk_lost),
        .pwr_on   (pwr_on)
    );

    ser7_sync #(.W(3)) u_bsync (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .d     ({pwr_on, clk_lost, pix_clk}),
        .q     (to_bit)
    );

    ser7_lanes #(
        .LANES   (SER_LANES),
        .RATIO   (SER_RATIO),
        .CLK_PAT (SER_CLK_PAT),
        .GOOD_FR (SER_GOOD_FR)
    ) u_lanes (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .pix_s     (to_bit[0]),
        .lost_s    (to_bit[1]),
        .pwr_s     (to_bit[2]),
        .word_i    (cap_word),
        .ser_o     (ser_o),
        .ser_oe    (ser_oe),
        .force_low (force_b)
    );
endmodule

// File: rtl/ser7_chk.sv
`timescale 1ns/1ps
// Property checker for ser7_tx, bound to every instance of the top.
// Assumes default clock pattern 1100011 (runs of at most four ones, three zeros).
module ser7_chk #(
    parameter int N      = 5,
    parameter int MAX_HI = 4,
    parameter int MAX_LO = 3
) (
    input logic         bit_clk,
    input logic         rst_n,
    input logic         lost_s,
    input logic         force_low,
    input logic [N-1:0] ser_o,
    input logic [N-1:0] ser_oe
);
    logic [3:0] hi_run;
    logic [3:0] lo_run;

    // run lengths of the clock lane while it is live
    always_ff @(posedge bit_clk) begin
        if (!rst_n || force_low || !ser_oe[N-1]) begin
            hi_run <= '0;
            lo_run <= '0;
        end else if (ser_o[N-1]) begin
            hi_run <= (hi_run == 4'hf) ? hi_run : hi_run + 1'b1;
            lo_run <= '0;
        end else begin
            lo_run <= (lo_run == 4'hf) ? lo_run : lo_run + 1'b1;
            hi_run <= '0;
        end
    end

    // R8
    oe_uniform_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (ser_oe == '0) || (ser_oe == '1));

    // R8
    disabled_low_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (ser_oe == '0) |-> (ser_o == '0));

    // R5
    lost_low_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lost_s |=> (ser_o == '0));

    // R3
    clk_hi_run_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        hi_run <= 4'(MAX_HI));

    // R3
    clk_lo_run_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lo_run <= 4'(MAX_LO));
endmodule

bind ser7_tx ser7_chk #(.N(ser7_pkg::SER_LANES + 1)) u_chk (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .lost_s    (to_bit[1]),
    .force_low (force_b),
    .ser_o     (ser_o),
    .ser_oe    (ser_oe)
);

// File: tb/tb_ser7_tx.sv
`timescale 1ns/100ps
module tb_ser7_tx;
    localparam int NV = 12;
    // each entry: {word on rising edge, word on falling edge}
    localparam logic [55:0] VEC [NV] = '{
        {28'h0FFFFFF, 28'h1234567},
        {28'hAAAAAAA, 28'h5555555},
        {28'h0000001, 28'h8000000},
        {28'h7F00FE1, 28'h00FF00F},
        {28'hC3C3C3C, 28'h3C3C3C3},
        {28'h1111111, 28'hEEEEEEE},
        {28'h0123456, 28'hFEDCBA9},
        {28'h8000001, 28'h7FFFFFE},
        {28'h00FC07F, 28'hF03FC00},
        {28'h2468ACE, 28'h13579BD},
        {28'hFFFFFFF, 28'h0F0F0F0},
        {28'h6DB6DB6, 28'h9249249}
    };

    logic        pix_clk = 0, bit_clk = 0, ref_clk = 0;
    logic        rst_n = 0, edge_rise = 1, pd_n = 1, pix_en = 1;
    logic [27:0] data_i = '0;
    logic [4:0]  ser_o, ser_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    ser7_tx dut (.pix_clk(pix_clk), .bit_clk(bit_clk), .ref_clk(ref_clk),
        .rst_n(rst_n), .edge_rise(edge_rise), .pd_n(pd_n), .data_i(data_i),
        .ser_o(ser_o), .ser_oe(ser_oe));

    initial begin #0.5; forever #1 bit_clk = ~bit_clk; end
    initial begin #1; forever #2.5 ref_clk = ~ref_clk; end
    initial forever begin
        if (pix_en) begin pix_clk = 1; #7; pix_clk = 0; #7; end
        else #14;
    end

    task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // serial decoder: frame start found from the clock lane's zero run
    int zrun = 0, bitpos = 0, idx = 0;
    bit mon_en = 0, locked = 0, mode_rise = 1;
    logic [27:0] acc = '0;

    function automatic logic [27:0] exp_word(input int i);
        return mode_rise ? VEC[i][55:28] : VEC[i][27:0];
    endfunction

    always @(negedge bit_clk) begin
        if (ser_o[4] == 1'b0) zrun++; else zrun = 0;
        if (zrun == 3) bitpos = 4; else bitpos = (bitpos + 1) % 7;
        for (int k = 0; k < 4; k++) acc[7*k + 6 - bitpos] = ser_o[k];
        if (bitpos == 6 && mon_en) begin
            if (!locked) begin
                if (acc == exp_word(0)) begin locked = 1; idx = 1; end
            end else if (idx < NV) begin
                // R1 R2 R3 R4: next frame carries the next word
                chk(acc == exp_word(idx), "R1 R2 R3 R4 word", acc, exp_word(idx));
                idx++;
            end
        end
    end

    task automatic run_table(input bit rise);
        edge_rise = rise; mode_rise = rise; locked = 0; idx = 0;
        repeat (6) @(posedge pix_clk);
        mon_en = 1;
        @(negedge pix_clk); #1 data_i = VEC[0][55:28];
        for (int i = 0; i < NV + 6; i++) begin
            @(posedge pix_clk); #1 data_i = (i < NV) ? VEC[i][27:0] : 28'h0;
            @(negedge pix_clk); #1 data_i = (i + 1 < NV) ? VEC[i+1][55:28] : 28'h0;
        end
        mon_en = 0;
        chk(locked && idx == NV, "R2 R4 stream complete", 28'(idx), 28'(NV));
    endtask

    // OR of each output over n bit cycles
    task automatic window(input int n, output logic [4:0] any_o, output logic [4:0] all_oe);
        any_o = '0; all_oe = '1;
        for (int i = 0; i < n; i++) begin
            @(negedge bit_clk);
            any_o  = any_o | ser_o;
            all_oe = all_oe & ser_oe;
        end
    endtask

    initial begin
        logic [4:0] ao, oe;
        bit short_ok;
        repeat (20) @(negedge ref_clk);
        // R9 reset state
        chk(ser_oe == 5'b0 && ser_o == 5'b0, "R9 reset", {18'b0, ser_oe, ser_o}, 28'h0);
        @(posedge ref_clk); #1 rst_n = 1;
        repeat (100) @(negedge ref_clk);
        chk(ser_oe == 5'b0, "R9 R7 enable held off", 28'(ser_oe), 28'h0);
        repeat (150) @(negedge ref_clk);
        chk(ser_oe == 5'h1f, "R9 R8 enabled", 28'(ser_oe), 28'h1f);

        run_table(1'b1);

        // R5: short stop keeps the pattern, long stop forces low
        pix_en = 0;
        repeat (20) @(negedge ref_clk);
        window(14, ao, oe);
        chk(ao[4] == 1'b1, "R5 before limit", 28'(ao), 28'h10);
        repeat (100) @(negedge ref_clk);
        window(14, ao, oe);
        chk(ao == 5'b0, "R5 lanes low", 28'(ao), 28'h0);
        chk(oe == 5'h1f, "R5 enables kept", 28'(oe), 28'h1f);

        // R6: resume only after two aligned frames
        pix_en = 1;
        @(posedge pix_clk); #21;
        window(1, ao, oe);
        chk(ao == 5'b0, "R6 still low", 28'(ao), 28'h0);
        repeat (10) @(posedge pix_clk);
        window(14, ao, oe);
        chk(ao[4] == 1'b1, "R6 resumed", 28'(ao), 28'h10);

        // R7: short pulse ignored
        short_ok = 1;
        @(posedge ref_clk); #1 pd_n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge ref_clk); if (ser_oe != 5'h1f) short_ok = 0;
        end
        #1 pd_n = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge ref_clk); if (ser_oe != 5'h1f) short_ok = 0;
        end
        chk(short_ok, "R7 short pulse", 28'(short_ok), 28'h1);

        // R7 R8: held power-down
        @(posedge ref_clk); #1 pd_n = 0;
        repeat (150) @(negedge ref_clk);
        chk(ser_oe == 5'h1f, "R7 not yet honoured", 28'(ser_oe), 28'h1f);
        repeat (100) @(negedge ref_clk);
        window(14, ao, oe);
        chk(ao == 5'b0 && oe == 5'b0, "R8 powered down", {18'b0, oe, ao}, 28'h0);
        @(posedge ref_clk); #1 pd_n = 1;
        repeat (250) @(negedge ref_clk);
        chk(ser_oe == 5'h1f, "R8 powered up", 28'(ser_oe), 28'h1f);

        run_table(1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #60000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule